// File: doc/BRIEF.md
# Real-Time Clock BCD Register Sequencer

This block moves calendar time between a user interface that holds binary fields and the packed-BCD clock registers of a real-time clock chip on an I2C bus. It does not drive the bus wires itself. It issues one byte-level command at a time to an I2C master: START, STOP, write a byte, or read a byte. It waits for that command to complete before it issues the next one.

A write transfer encodes centiseconds, seconds, minutes and hours into BCD and sends them as one time group. The day of month, with the two low year bits packed above it, and the month go out as a second date group. Either group can be left out. The block checks the range of every field it is about to send. If any field is out of range, no bus command is issued and an error is reported.

A read transfer fetches all six clock registers in a single combined transaction. It then strips the flag bits and decodes the BCD. It repairs a zero day or month to 1. A byte that the slave does not acknowledge ends the transfer with a STOP and sets a failure flag.

Top module: `rtc_bcd_seq`

## Requirements
- R1: A write with the time group enabled issues, in order: START, write 0xA0, write offset 0x01, then the BCD bytes of centiseconds, seconds, minutes and hours, then STOP. BCD of v is (v/10)*16 + v%10. Bus operation codes are 0 START, 1 STOP, 2 WRITE, 3 READ.
- R2: A write with the date group enabled issues START, write 0xA0, write offset 0x05, then the day byte, then BCD month, then STOP. The day byte holds BCD day in bits 5:0 and year_lo in bits 7:6. When both groups are enabled, the date group follows the time group's STOP.
- R3: skip_time leaves out the whole time group and skip_date leaves out the whole date group. With both flags set, no bus operation is issued and done still pulses.
- R4: If a field of an enabled group is out of range, no bus operation is issued, err_range is set and done pulses. The ranges are centiseconds 0..99, seconds and minutes 0..59, hours 0..23, day 1..31 and month 1..12. Fields of a skipped group are not checked.
- R5: A read issues START, write 0xA0, write 0x01, START, write 0xA1, then six READ operations, then STOP. m_rd_nack is 0 on the first five READs and 1 on the sixth.
- R6: After a read, the rd_* outputs hold the decoded bytes in register order. The fifth byte is masked to bits 5:0 and the sixth to bits 4:0 before decoding, which is high nibble*10 + low nibble.
- R7: A decoded day or month of zero is reported as 1.
- R8: When the slave does not acknowledge a written byte (m_ack_err with m_done), the next operation is STOP and no further byte is sent. err_nack is then set and done pulses.
- R9: start_wr and start_rd are ignored while busy is high.
- R10: After reset, busy, done, m_req, err_range and err_nack are 0. m_req is never high while busy is low.
- R11: Once m_req rises, it stays high with a stable operation and byte until m_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_wr | input | 1 | Start a write transfer (pulse) |
| start_rd | input | 1 | Start a read transfer (pulse) |
| skip_time | input | 1 | Leave the time group unwritten |
| skip_date | input | 1 | Leave the date group unwritten |
| in_cs | input | 7 | Binary centiseconds to write |
| in_sec | input | 7 | Binary seconds to write |
| in_min | input | 7 | Binary minutes to write |
| in_hr | input | 7 | Binary hours to write |
| in_day | input | 7 | Binary day of month to write |
| in_mon | input | 7 | Binary month to write |
| year_lo | input | 2 | Low two year bits packed into the day register |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err_range | output | 1 | Last write was refused for a field out of range |
| err_nack | output | 1 | Last transfer was aborted on a missing acknowledge |
| rd_cs | output | 7 | Centiseconds from the last good read |
| rd_sec | output | 7 | Seconds from the last good read |
| rd_min | output | 7 | Minutes from the last good read |
| rd_hr | output | 7 | Hours from the last good read |
| rd_day | output | 7 | Day from the last good read |
| rd_mon | output | 7 | Month from the last good read |
| m_req | output | 1 | Operation request to the I2C master |
| m_op | output | 2 | Operation: 0 START, 1 STOP, 2 WRITE, 3 READ |
| m_wbyte | output | 8 | Byte to write |
| m_rd_nack | output | 1 | Send NACK after this read byte |
| m_done | input | 1 | Master finished the requested operation |
| m_rbyte | input | 8 | Byte received by a READ |
| m_ack_err | input | 1 | Slave did not acknowledge the written byte |

## Verification
A wrong step counter or phase shows up at once on the master interface. The operation or byte logged at the next m_done is different from the expected script, or the sequence is too long or too short. Each transfer is compared entry by entry. A fault in the decode masks or the zero repair appears only on rd_day and rd_mon, one cycle after the final STOP completes. A lost abort shows up as an extra written byte right after the refused one.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        PH_TIME = 2'd0,
        PH_DATE = 2'd1,
        PH_READ = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_REQ   = 2'd1,
        S_ABORT = 2'd2,
        S_DONE  = 2'd3
    } state_e;

    localparam int NREG     = 6;
    localparam int FIELD_W  = 7;
    localparam int STEP_W   = 4;
    localparam logic [7:0] TIME_OFS = 8'h01;
    localparam logic [7:0] DATE_OFS = 8'h05;
    localparam logic [3:0] RD_FIRST = 4'd5;
    localparam logic [3:0] RD_LAST  = 4'd10;
endpackage

// File: rtl/rtc_bin2bcd.sv
module rtc_bin2bcd #(
    parameter int W = 7
) (
    input  logic [W-1:0] bin,
    output logic [7:0]   bcd
);
    logic [W-1:0] tens;
    logic [W-1:0] ones;

    always_comb begin
        tens = bin / W'(10);
        ones = bin % W'(10);
        bcd  = {tens[3:0], ones[3:0]};
    end
endmodule

// File: rtl/rtc_bcd2bin.sv
module rtc_bcd2bin #(
    parameter logic [7:0] MASK      = 8'hFF,
    parameter bit         FORCE_ONE = 1'b0
) (
    input  logic [7:0] bcd,
    output logic [7:0] bin
);
    logic [7:0] m;
    logic [7:0] hi;
    logic [7:0] raw;

    always_comb begin
        m   = bcd & MASK;
        hi  = {4'd0, m[7:4]};
        raw = (hi << 3) + (hi << 1) + {4'd0, m[3:0]};
    end

    generate
        if (FORCE_ONE) begin : g_force
            assign bin = (raw == 8'd0) ? 8'd1 : raw;
        end else begin : g_plain
            assign bin = raw;
        end
    endgenerate
endmodule

// File: rtl/rtc_range_chk.sv
module rtc_range_chk #(
    parameter int W = 7
) (
    input  logic [W-1:0] cs,
    input  logic [W-1:0] sec,
    input  logic [W-1:0] min,
    input  logic [W-1:0] hr,
    input  logic [W-1:0] day,
    input  logic [W-1:0] mon,
    output logic         time_bad,
    output logic         date_bad
);
    always_comb begin
        time_bad = (cs > W'(99)) || (sec > W'(59)) || (min > W'(59)) || (hr > W'(23));
        date_bad = (day == '0) || (day > W'(31)) || (mon == '0) || (mon > W'(12));
    end
endmodule

// File: rtl/rtc_step_dec.sv
module rtc_step_dec
    import rtc_bcd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  phase_e              phase,
    input  logic [STEP_W-1:0]   step,
    input  logic [NREG-1:0][7:0] wb,
    output bus_op_e             op,
    output logic [7:0]          wbyte,
    output logic                rd_nack,
    output logic                last
);
    localparam logic [7:0] ADDR_W = {DEV_ADDR, 1'b0};
    localparam logic [7:0] ADDR_R = {DEV_ADDR, 1'b1};

    logic [STEP_W-1:0] toff;
    logic [2:0]        tidx;

    always_comb begin
        toff    = step - 4'd3;
        tidx    = toff[2:0];
        op      = OP_WRITE;
        wbyte   = 8'h00;
        rd_nack = 1'b0;
        last    = 1'b0;
        unique case (phase)
            PH_TIME: begin
                if (step == 4'd0) op = OP_START;
                else if (step == 4'd1) wbyte = ADDR_W;
                else if (step == 4'd2) wbyte = TIME_OFS;
                else if (step <= 4'd6) wbyte = wb[tidx];
                else begin
                    op   = OP_STOP;
                    last = 1'b1;
                end
            end
            PH_DATE: begin
                if (step == 4'd0) op = OP_START;
                else if (step == 4'd1) wbyte = ADDR_W;
                else if (step == 4'd2) wbyte = DATE_OFS;
                else if (step == 4'd3) wbyte = wb[4];
                else if (step == 4'd4) wbyte = wb[5];
                else begin
                    op   = OP_STOP;
                    last = 1'b1;
                end
            end
            default: begin
                if (step == 4'd0 || step == 4'd3) op = OP_START;
                else if (step == 4'd1) wbyte = ADDR_W;
                else if (step == 4'd2) wbyte = TIME_OFS;
                else if (step == 4'd4) wbyte = ADDR_R;
                else if (step <= RD_LAST) begin
                    op      = OP_READ;
                    rd_nack = (step == RD_LAST);
                end else begin
                    op   = OP_STOP;
                    last = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/rtc_bcd_seq.sv
module rtc_bcd_seq
    import rtc_bcd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_wr,
    input  logic       start_rd,
    input  logic       skip_time,
    input  logic       skip_date,
    input  logic [6:0] in_cs,
    input  logic [6:0] in_sec,
    input  logic [6:0] in_min,
    input  logic [6:0] in_hr,
    input  logic [6:0] in_day,
    input  logic [6:0] in_mon,
    input  logic [1:0] year_lo,
    output logic       busy,
    output logic       done,
    output logic       err_range,
    output logic       err_nack,
    output logic [6:0] rd_cs,
    output logic [6:0] rd_sec,
    output logic [6:0] rd_min,
    output logic [6:0] rd_hr,
    output logic [6:0] rd_day,
    output logic [6:0] rd_mon,
    output logic       m_req,
    output logic [1:0] m_op,
    output logic [7:0] m_wbyte,
    output logic       m_rd_nack,
    input  logic       m_done,
    input  logic [7:0] m_rbyte,
    input  logic       m_ack_err
);
    typedef struct packed {
        state_e                st;
        phase_e                ph;
        logic [STEP_W-1:0]     step;
        logic [NREG-1:0][7:0]  wb;
        logic [NREG-1:0][7:0]  rx;
        logic [NREG-1:0][7:0]  res;
        logic                  skip_date;
        logic                  err_range;
        logic                  err_nack;
        logic                  done;
    } regs_t;

    regs_t q, d;

    logic [NREG-1:0][FIELD_W-1:0] bin_in;
    logic [NREG-1:0][7:0]         enc;
    logic [NREG-1:0][7:0]         dec;
    logic [NREG-1:0][7:0]         wb_new;
    logic                         time_bad, date_bad;
    bus_op_e                      s_op;
    logic [7:0]                   s_byte;
    logic                         s_nack, s_last;
    logic [STEP_W-1:0]            roff;
    logic [2:0]                   ridx;

    assign bin_in = {in_mon, in_day, in_hr, in_min, in_sec, in_cs};

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_field
            rtc_bin2bcd #(.W(FIELD_W)) u_enc (
                .bin (bin_in[gi]),
                .bcd (enc[gi])
            );
            rtc_bcd2bin #(
                .MASK      ((gi == 4) ? 8'h3F : (gi == 5) ? 8'h1F : 8'hFF),
                .FORCE_ONE (gi >= 4)
            ) u_dec (
                .bcd (q.rx[gi]),
                .bin (dec[gi])
            );
        end
    endgenerate

    rtc_range_chk #(.W(FIELD_W)) u_chk_range (
        .cs       (in_cs),
        .sec      (in_sec),
        .min      (in_min),
        .hr       (in_hr),
        .day      (in_day),
        .mon      (in_mon),
        .time_bad (time_bad),
        .date_bad (date_bad)
    );

    rtc_step_dec #(.DEV_ADDR(DEV_ADDR)) u_step (
        .phase   (q.ph),
        .step    (q.step),
        .wb      (q.wb),
        .op      (s_op),
        .wbyte   (s_byte),
        .rd_nack (s_nack),
        .last    (s_last)
    );

    always_comb begin
        wb_new    = enc;
        wb_new[4] = {year_lo, enc[4][5:0]};
        roff      = q.step - RD_FIRST;
        ridx      = roff[2:0];
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start_wr) begin
                    d.err_range = 1'b0;
                    d.err_nack  = 1'b0;
                    d.wb        = wb_new;
                    d.skip_date = skip_date;
                    d.step      = '0;
                    if ((!skip_time && time_bad) || (!skip_date && date_bad)) begin
                        d.err_range = 1'b1;
                        d.st        = S_DONE;
                    end else if (!skip_time) begin
                        d.ph = PH_TIME;
                        d.st = S_REQ;
                    end else if (!skip_date) begin
                        d.ph = PH_DATE;
                        d.st = S_REQ;
                    end else begin
                        d.st = S_DONE;
                    end
                end else if (start_rd) begin
                    d.err_range = 1'b0;
                    d.err_nack  = 1'b0;
                    d.ph        = PH_READ;
                    d.step      = '0;
                    d.st        = S_REQ;
                end
            end
            S_REQ: begin
                if (m_done) begin
                    if (s_op == OP_WRITE && m_ack_err) begin
                        d.st = S_ABORT;
                    end else if (s_last) begin
                        if (q.ph == PH_TIME && !q.skip_date) begin
                            d.ph   = PH_DATE;
                            d.step = '0;
                        end else begin
                            d.st = S_DONE;
                            if (q.ph == PH_READ) d.res = dec;
                        end
                    end else begin
                        if (s_op == OP_READ && ridx < 3'd6) d.rx[ridx] = m_rbyte;
                        d.step = q.step + 4'd1;
                    end
                end
            end
            S_ABORT: begin
                if (m_done) begin
                    d.err_nack = 1'b1;
                    d.st       = S_DONE;
                end
            end
            default: begin
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy      = (q.st != S_IDLE);
        done      = q.done;
        err_range = q.err_range;
        err_nack  = q.err_nack;
        m_req     = (q.st == S_REQ) || (q.st == S_ABORT);
        m_op      = (q.st == S_ABORT) ? OP_STOP : s_op;
        m_wbyte   = (q.st == S_ABORT) ? 8'h00 : s_byte;
        m_rd_nack = (q.st == S_REQ) && s_nack;
        rd_cs     = q.res[0][6:0];
        rd_sec    = q.res[1][6:0];
        rd_min    = q.res[2][6:0];
        rd_hr     = q.res[3][6:0];
        rd_day    = q.res[4][6:0];
        rd_mon    = q.res[5][6:0];
    end
endmodule

// File: rtl/rtc_bcd_seq_chk.sv
module rtc_bcd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err_range,
    input logic       m_req,
    input logic [1:0] m_op,
    input logic [7:0] m_wbyte,
    input logic       m_rd_nack,
    input logic       m_done,
    input logic       m_ack_err
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_done) |=> (m_req && $stable(m_op) && $stable(m_wbyte)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_req);

    assert_no_bus_on_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_range |-> !m_req);

    assert_abort_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_done && m_op == 2'd2 && m_ack_err) |=> (m_req && m_op == 2'd1));

    assert_nack_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_rd_nack) |-> (m_op == 2'd3));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind rtc_bcd_seq rtc_bcd_seq_chk u_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err_range (err_range),
    .m_req     (m_req),
    .m_op      (m_op),
    .m_wbyte   (m_wbyte),
    .m_rd_nack (m_rd_nack),
    .m_done    (m_done),
    .m_ack_err (m_ack_err)
);

// File: tb/rtc_bcd_seq_test.sv
module rtc_bcd_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_wr = 1'b0, start_rd = 1'b0;
    logic       skip_time = 1'b0, skip_date = 1'b0;
    logic [6:0] in_cs = '0, in_sec = '0, in_min = '0, in_hr = '0, in_day = 7'd1, in_mon = 7'd1;
    logic [1:0] year_lo = '0;
    logic       busy, done, err_range, err_nack;
    logic [6:0] rd_cs, rd_sec, rd_min, rd_hr, rd_day, rd_mon;
    logic       m_req, m_rd_nack;
    logic [1:0] m_op;
    logic [7:0] m_wbyte;
    logic       m_done = 1'b0;
    logic [7:0] m_rbyte = '0;
    logic       m_ack_err = 1'b0;

    int checks = 0;
    int errors = 0;
    int log_v [0:31];
    int log_n = 0;
    int exp_v [0:31];
    int exp_n = 0;
    logic [7:0] rdq [0:5];
    int rd_i = 0;
    int nack_at = -1;
    int req_drop = 0;
    int cnt = 0;

    always #2 clk = ~clk;

    rtc_bcd_seq uut (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
        .skip_time(skip_time), .skip_date(skip_date),
        .in_cs(in_cs), .in_sec(in_sec), .in_min(in_min), .in_hr(in_hr),
        .in_day(in_day), .in_mon(in_mon), .year_lo(year_lo),
        .busy(busy), .done(done), .err_range(err_range), .err_nack(err_nack),
        .rd_cs(rd_cs), .rd_sec(rd_sec), .rd_min(rd_min), .rd_hr(rd_hr),
        .rd_day(rd_day), .rd_mon(rd_mon),
        .m_req(m_req), .m_op(m_op), .m_wbyte(m_wbyte), .m_rd_nack(m_rd_nack),
        .m_done(m_done), .m_rbyte(m_rbyte), .m_ack_err(m_ack_err)
    );

    // byte-level master model: answers each request after three cycles
    initial begin
        forever begin
            @(negedge clk);
            if (m_done) begin
                m_done    = 1'b0;
                m_ack_err = 1'b0;
                cnt       = 0;
            end else if (m_req) begin
                if (cnt == 2) begin
                    if (log_n < 32) log_v[log_n] = int'(m_op) * 512 + int'(m_rd_nack) * 256 + int'(m_wbyte);
                    if (m_op == 2'd3) begin
                        m_rbyte = rdq[rd_i % 6];
                        rd_i++;
                    end
                    m_ack_err = (m_op == 2'd2) && (log_n == nack_at);
                    log_n++;
                    m_done = 1'b1;
                end else begin
                    cnt++;
                end
            end else begin
                if (cnt != 0) req_drop++;
                cnt = 0;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    task automatic push(input int op, input int nk, input int b);
        exp_v[exp_n] = op * 512 + nk * 256 + b;
        exp_n++;
    endtask

    task automatic clear_log();
        log_n = 0; exp_n = 0; rd_i = 0;
    endtask

    task automatic cmp_log(input string tag);
        check({tag, " op count"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            check($sformatf("%s op %0d", tag, i), log_v[i], exp_v[i]);
        end
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        check({tag, " done seen"}, int'(done), 1);
        @(negedge clk);
    endtask

    task automatic do_write(input string tag);
        clear_log();
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        wait_done(tag);
    endtask

    task automatic do_read(input string tag);
        clear_log();
        start_rd = 1'b1;
        @(negedge clk);
        start_rd = 1'b0;
        wait_done(tag);
    endtask

    task automatic set_fields(input int c, s, mi, h, dy, mo, y);
        in_cs = 7'(c); in_sec = 7'(s); in_min = 7'(mi); in_hr = 7'(h);
        in_day = 7'(dy); in_mon = 7'(mo); year_lo = 2'(y);
    endtask

    task automatic push_time(input int c, s, mi, h);
        push(0, 0, 0); push(2, 0, 8'hA0); push(2, 0, 8'h01);
        push(2, 0, bcd(c)); push(2, 0, bcd(s)); push(2, 0, bcd(mi)); push(2, 0, bcd(h));
        push(1, 0, 0);
    endtask

    task automatic push_date(input int dy, mo, y);
        push(0, 0, 0); push(2, 0, 8'hA0); push(2, 0, 8'h05);
        push(2, 0, y * 64 + bcd(dy)); push(2, 0, bcd(mo));
        push(1, 0, 0);
    endtask

    task automatic push_read();
        push(0, 0, 0); push(2, 0, 8'hA0); push(2, 0, 8'h01);
        push(0, 0, 0); push(2, 0, 8'hA1);
        for (int i = 0; i < 6; i++) push(3, (i == 5) ? 1 : 0, 0);
        push(1, 0, 0);
    endtask

    task automatic t_reset();
        check("R10 busy after reset", int'(busy), 0);
        check("R10 m_req after reset", int'(m_req), 0);
        check("R10 done after reset", int'(done), 0);
        check("R10 err_range after reset", int'(err_range), 0);
        check("R10 err_nack after reset", int'(err_nack), 0);
    endtask

    task automatic t_write_both();
        skip_time = 0; skip_date = 0;
        set_fields(45, 7, 59, 23, 31, 12, 2);
        do_write("R1 R2 full write");
        push_time(45, 7, 59, 23);
        push_date(31, 12, 2);
        cmp_log("R1 R2 full write");
        check("R1 no range error", int'(err_range), 0);
        check("R2 no nack error", int'(err_nack), 0);
        check("R11 request held until done", req_drop, 0);
    endtask

    task automatic t_skips();
        skip_time = 1; skip_date = 0;
        set_fields(0, 0, 0, 0, 9, 1, 3);
        do_write("R3 skip time");
        push_date(9, 1, 3);
        cmp_log("R3 skip time");
        skip_time = 0; skip_date = 1;
        set_fields(99, 0, 10, 0, 0, 0, 0);
        do_write("R3 skip date");
        push_time(99, 0, 10, 0);
        cmp_log("R3 skip date");
        check("R4 skipped date not range checked", int'(err_range), 0);
        skip_time = 1; skip_date = 1;
        do_write("R3 skip both");
        cmp_log("R3 skip both");
        skip_time = 0; skip_date = 0;
    endtask

    task automatic t_range();
        set_fields(10, 10, 60, 10, 10, 10, 0);
        do_write("R4 minutes 60");
        cmp_log("R4 minutes 60");
        check("R4 err_range set", int'(err_range), 1);
        set_fields(10, 10, 10, 10, 10, 13, 0);
        do_write("R4 month 13");
        cmp_log("R4 month 13");
        check("R4 err_range month", int'(err_range), 1);
    endtask

    task automatic t_read();
        rdq[0] = 8'h99; rdq[1] = 8'h59; rdq[2] = 8'h37;
        rdq[3] = 8'h21; rdq[4] = 8'hF1; rdq[5] = 8'hE9;
        do_read("R5 read");
        push_read();
        cmp_log("R5 read");
        check("R6 rd_cs", int'(rd_cs), 99);
        check("R6 rd_sec", int'(rd_sec), 59);
        check("R6 rd_min", int'(rd_min), 37);
        check("R6 rd_hr", int'(rd_hr), 21);
        check("R6 rd_day masked", int'(rd_day), 31);
        check("R6 rd_mon masked", int'(rd_mon), 9);
        check("R6 range flag cleared", int'(err_range), 0);
    endtask

    task automatic t_zero();
        rdq[0] = 8'h00; rdq[1] = 8'h00; rdq[2] = 8'h00;
        rdq[3] = 8'h00; rdq[4] = 8'hC0; rdq[5] = 8'hE0;
        do_read("R7 zero read");
        check("R7 day forced to 1", int'(rd_day), 1);
        check("R7 month forced to 1", int'(rd_mon), 1);
        check("R7 hours stay 0", int'(rd_hr), 0);
    endtask

    task automatic t_nack();
        set_fields(1, 2, 3, 4, 5, 6, 0);
        nack_at = 2;
        do_write("R8 nack");
        nack_at = -1;
        push(0, 0, 0); push(2, 0, 8'hA0); push(2, 0, 8'h01); push(1, 0, 0);
        cmp_log("R8 nack");
        check("R8 err_nack set", int'(err_nack), 1);
    endtask

    task automatic t_busy();
        rdq[0] = 8'h12; rdq[1] = 8'h34; rdq[2] = 8'h56;
        rdq[3] = 8'h08; rdq[4] = 8'h15; rdq[5] = 8'h07;
        set_fields(1, 2, 3, 4, 5, 6, 0);
        clear_log();
        start_rd = 1'b1;
        @(negedge clk);
        start_rd = 1'b0;
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        wait_done("R9 busy read");
        repeat (20) @(negedge clk);
        push_read();
        cmp_log("R9 write ignored while busy");
        check("R9 idle after", int'(busy), 0);
        check("R9 read result minutes", int'(rd_min), 56);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_write_both();
        t_skips();
        t_range();
        t_read();
        t_zero();
        t_nack();
        t_busy();
        check("R11 no early request drop", req_drop, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule